// File: doc/BRIEF.md
# NAND Device Command Front End

This block is the device-side command interpreter of a small-page NAND memory with a multiplexed 8-bit bus. On every rising edge of the write strobe it classifies the bus byte as a command (command latch high), an address byte (address latch high) or a data byte (both low). It keeps a three-area column pointer and assembles the address cycles into a column start and a 14-bit row. It writes program data bytes out on a page register port, runs a busy timer whose length for each operation is a parameter, and keeps the pass/fail status.

Strobes are sampled on the system clock, and an edge is acted on in the clock cycle after the strobe is seen high again. Status and identifier bytes are driven on the output byte while the read strobe is low, and the identifier index moves on each rising read strobe. The cell array is outside the block. It reports its pass/fail result on an input that is sampled when a program or erase busy period ends.

Top module: `nand_cmd_front`

## Requirements
- R1: After rst_n the block is ready (rdy=1), io_oe is 0, row_addr is 0, no page write is issued, and a status read (command 70h) returns C0h while wp_n is high.
- R2: A read or program takes three address cycles: the column byte, then row[7:0], then row[13:8] from bits 5:0 (bits 7:6 are dropped). Address cycles after the last required one change neither the row nor the column.
- R3: The column start is the address byte for pointer command 00h, 256 plus the byte for 01h, and 512 plus bits 3:0 only for 50h. Each data byte after that is written on the page port at the next column, and no byte is written at column 528 or above.
- R4: Pointer settings from 00h and 50h stay in force across operations. A 01h setting is used by one operation only: once any read, program, erase or reset is launched, the pointer goes back to the 0–255 area.
- R5: A command code outside {00h,01h,50h,80h,10h,60h,D0h,70h,90h,FFh} is ignored, and a program sequence that is in progress goes on accepting data.
- R6: While busy, only 70h and FFh are accepted. Other commands, address bytes and data bytes are ignored.
- R7: The status byte is {wp_n, ready, 5'b00000, fail}, where fail is 1 when the last program or erase reported failure.
- R8: An accepted FFh clears row and column to 0, pulses pg_fill for one cycle, clears fail and keeps the block busy for T_RST cycles. An FFh is accepted while a program is busy and aborts it. An FFh issued while a reset is still running is ignored and does not restart the timer.
- R9: A 10h with no data byte after 80h and its address does not start a program. A D0h that does not follow 60h and two row cycles does not start an erase.
- R10: After 90h and one address byte, the first read returns ECh and every later read returns E6h.
- R11: After 70h the output stays in status mode until another command is accepted, and each read shows the live status, including the change from busy to ready.
- R12: rdy falls in the first clock after the edge that confirms an operation (the third address cycle of a read, 10h, D0h, FFh) and stays low for exactly T_READ, T_PROG, T_ERASE or T_RST cycles. At the end of a program or erase, array_fail is latched as the fail bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, byte taken on rising edge |
| re_n | input | 1 | Read strobe, output while low |
| wp_n | input | 1 | Write-protect, low means protected |
| io_in | input | 8 | Bus byte in |
| array_fail | input | 1 | Cell array result for the finished program or erase |
| io_out | output | 8 | Status or identifier byte |
| io_oe | output | 1 | Output enable for io_out |
| rdy | output | 1 | High when ready, low when busy |
| pg_we | output | 1 | Page register write pulse |
| pg_col | output | COL_W | Page register column for the write |
| pg_din | output | 8 | Page register write data |
| pg_fill | output | 1 | One-cycle pulse: set all page bytes to FFh |
| row_addr | output | ROW_W | Assembled row address |

## Verification
The bench goes after the one-shot upper-half pointer. A design that keeps the 01h area would place the second program's data 256 columns too high, and one that drops 50h would lose the spare offset on the next program. It sends 50h, data and status reads during a busy program. A filter that lets these through would move the pointer, write the page or show a ready status too early. It also sends a second FFh during a reset, where a restarted timer would make the busy period longer, and a bare 10h, where a design that does not check for data would go busy. Random program sequences over all pointer areas and start bytes near 527 check the column count and the stop at the end of the page.

// File: rtl/nfe_pkg.sv
`timescale 1ns/1ps
// Shared types and command codes for the NAND command front end.
// Assumes: 8-bit bus, command codes fixed by the device protocol.
package nfe_pkg;
    typedef enum logic [1:0] {AREA_LO, AREA_HI, AREA_SPARE} area_t;
    typedef enum logic [2:0] {MD_NONE, MD_READ, MD_PROG, MD_ERASE, MD_ID} mode_t;
    typedef enum logic [1:0] {OUT_NONE, OUT_STAT, OUT_ID} osel_t;
    typedef enum logic [1:0] {OP_READ, OP_PROG, OP_ERASE, OP_RST} op_t;

    localparam logic [7:0] C_PTR_LO  = 8'h00;
    localparam logic [7:0] C_PTR_HI  = 8'h01;
    localparam logic [7:0] C_PTR_SP  = 8'h50;
    localparam logic [7:0] C_PG_SET  = 8'h80;
    localparam logic [7:0] C_PG_GO   = 8'h10;
    localparam logic [7:0] C_ER_SET  = 8'h60;
    localparam logic [7:0] C_ER_GO   = 8'hD0;
    localparam logic [7:0] C_STAT    = 8'h70;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_RESET   = 8'hFF;
    localparam logic [7:0] ID_MAKER  = 8'hEC;
    localparam logic [7:0] ID_DEVICE = 8'hE6;

    // True for any code in the supported command set.
    function automatic logic cmd_legal(input logic [7:0] c);
        case (c)
            C_PTR_LO, C_PTR_HI, C_PTR_SP, C_PG_SET, C_PG_GO,
            C_ER_SET, C_ER_GO, C_STAT, C_IDENT, C_RESET: cmd_legal = 1'b1;
            default: cmd_legal = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/nfe_ptr.sv
`timescale 1ns/1ps
// Column pointer area register.
// Holds which page area (low half, high half, spare) the next column byte refers to.
// Low and spare settings persist; the high-half setting is dropped once an operation launches.
// Assumes: the set strobes and op_launch never fire in the same cycle.
module nfe_ptr
    import nfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  set_lo,
    input  logic  set_hi,
    input  logic  set_sp,
    input  logic  op_launch,
    output area_t area
);
    // Area update: explicit sets win, otherwise the high half is one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n)                                area <= AREA_LO;
        else if (set_lo)                           area <= AREA_LO;
        else if (set_hi)                           area <= AREA_HI;
        else if (set_sp)                           area <= AREA_SPARE;
        else if (op_launch && area == AREA_HI)     area <= AREA_LO;
    end

    // R4: after a launch the high-half pointer is gone
    a_r4_hi_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (op_launch && area == AREA_HI && !set_lo && !set_hi && !set_sp) |=> area == AREA_LO);
    // R4: low and spare settings survive launches
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (area != AREA_HI && !set_lo && !set_hi && !set_sp) |=> $stable(area));
endmodule

// File: rtl/nfe_addr.sv
`timescale 1ns/1ps
// Address cycle assembler and running column counter.
// Counts the address cycles an operation needs (three, two row-only, or one),
// turns the column byte into a start column per pointer area, and moves the column on each data byte.
// Assumes: start strobes, addr_we and inc are mutually exclusive in a cycle.
module nfe_addr
    import nfe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int COL_W       = 10,
    parameter int ROW_W       = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start_full,
    input  logic             start_row,
    input  logic             start_one,
    input  logic             addr_we,
    input  logic [7:0]       abyte,
    input  area_t            area,
    input  logic             inc,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             complete,
    output logic             last_cyc
);
    localparam int HALF = MAIN_BYTES / 2;
    localparam int SP_W = $clog2(SPARE_BYTES);
    localparam int HI_W = ROW_W - 8;

    logic [1:0]       cnt, lim;
    logic [COL_W-1:0] col_start;

    // Column start from pointer area and column byte.
    always_comb begin
        case (area)
            AREA_HI:    col_start = COL_W'(HALF) + COL_W'(abyte);
            AREA_SPARE: col_start = COL_W'(MAIN_BYTES) + COL_W'(abyte[SP_W-1:0]);
            default:    col_start = COL_W'(abyte);
        endcase
    end

    assign complete = (cnt == lim);
    assign last_cyc = addr_we && !complete && (cnt + 2'd1 == lim);

    // Cycle counter, address latches and column advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col <= '0; row <= '0; cnt <= 2'd0; lim <= 2'd3;
        end else if (start_full) begin
            cnt <= 2'd0; lim <= 2'd3;
        end else if (start_row) begin
            cnt <= 2'd1; lim <= 2'd3;
        end else if (start_one) begin
            cnt <= 2'd0; lim <= 2'd1;
        end else if (addr_we && !complete) begin
            case (cnt)
                2'd0:    if (lim != 2'd1) col <= col_start;
                2'd1:    row[7:0] <= abyte;
                default: row[ROW_W-1:8] <= abyte[HI_W-1:0];
            endcase
            cnt <= cnt + 2'd1;
        end else if (inc) begin
            col <= col + COL_W'(1);
        end
    end

    // R2: surplus address cycles leave row and column untouched
    a_r2_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && complete && !clr && !start_full && !start_row && !start_one && !inc)
        |=> ($stable(row) && $stable(col)));
endmodule

// File: rtl/nfe_busy.sv
`timescale 1ns/1ps
// Busy timer: a start loads a cycle count; busy holds until it runs out.
// done pulses in the last busy cycle. A new start reloads the count.
// Assumes: len is at least 1.
module nfe_busy #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Down-counter of remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= len;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R12: busy rises in the cycle after a start
    a_r12_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len != '0) |=> busy);
    // R12: busy never appears without a start
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/nand_cmd_front.sv
`timescale 1ns/1ps
// NAND device command front end.
// Decodes bus bytes on each write strobe rising edge, enforces the busy-time
// command filter, tracks the column pointer, status and identifier readout,
// and writes program data to an external page register.
// Assumes: strobes are slow relative to clk and are sampled directly; the array
// result array_fail is stable when a program or erase busy period ends.
module nand_cmd_front
    import nfe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int ROW_W       = 14,
    parameter int T_READ      = 500,
    parameter int T_PROG      = 20000,
    parameter int T_ERASE     = 200000,
    parameter int T_RST       = 250,
    localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
    localparam int COL_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic             wp_n,
    input  logic [7:0]       io_in,
    input  logic             array_fail,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             rdy,
    output logic             pg_we,
    output logic [COL_W-1:0] pg_col,
    output logic [7:0]       pg_din,
    output logic             pg_fill,
    output logic [ROW_W-1:0] row_addr
);
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int T_MAX = max2(max2(T_READ, T_PROG), max2(T_ERASE, T_RST));
    localparam int TW    = $clog2(T_MAX + 1);

    logic we_q, re_q, busy, done;
    logic we_evt, re_evt, cmd_evt, adr_evt, dat_evt;
    logic take_cmd, go_prog, go_erase, go_rst, go_read, launch;
    logic adr_ok, dat_ok, seen, fail_q, id_idx, complete, last_cyc;
    logic [COL_W-1:0] col;
    logic [TW-1:0]    len;
    mode_t mode;
    osel_t osel;
    op_t   op_q, op_nx;
    area_t area;

    // Strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin we_q <= 1'b1; re_q <= 1'b1; end
        else        begin we_q <= we_n; re_q <= re_n; end
    end

    assign we_evt  = !we_q && we_n;
    assign re_evt  = !re_q && re_n;
    assign cmd_evt = we_evt && cle && !ale;
    assign adr_evt = we_evt && ale && !cle;
    assign dat_evt = we_evt && !cle && !ale;

    assign take_cmd = cmd_evt && cmd_legal(io_in) &&
                      (!busy || io_in == C_STAT || (io_in == C_RESET && op_q != OP_RST));
    assign go_rst   = take_cmd && io_in == C_RESET;
    assign go_prog  = take_cmd && io_in == C_PG_GO && mode == MD_PROG && seen && complete;
    assign go_erase = take_cmd && io_in == C_ER_GO && mode == MD_ERASE && complete;
    assign adr_ok   = adr_evt && !busy && mode != MD_NONE;
    assign go_read  = mode == MD_READ && last_cyc;
    assign launch   = go_rst || go_prog || go_erase || go_read;
    assign dat_ok   = dat_evt && !busy && mode == MD_PROG && complete &&
                      (col < COL_W'(PAGE_BYTES));

    // Operation selection and its busy length.
    always_comb begin
        if (go_rst)        begin op_nx = OP_RST;   len = TW'(T_RST);   end
        else if (go_prog)  begin op_nx = OP_PROG;  len = TW'(T_PROG);  end
        else if (go_erase) begin op_nx = OP_ERASE; len = TW'(T_ERASE); end
        else               begin op_nx = OP_READ;  len = TW'(T_READ);  end
    end

    nfe_ptr u_ptr (
        .clk(clk), .rst_n(rst_n),
        .set_lo(take_cmd && io_in == C_PTR_LO),
        .set_hi(take_cmd && io_in == C_PTR_HI),
        .set_sp(take_cmd && io_in == C_PTR_SP),
        .op_launch(launch), .area(area)
    );

    nfe_addr #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
               .COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(go_rst),
        .start_full(take_cmd && (io_in == C_PTR_LO || io_in == C_PTR_HI ||
                                 io_in == C_PTR_SP || io_in == C_PG_SET)),
        .start_row(take_cmd && io_in == C_ER_SET),
        .start_one(take_cmd && io_in == C_IDENT),
        .addr_we(adr_ok), .abyte(io_in), .area(area), .inc(dat_ok),
        .col(col), .row(row_addr), .complete(complete), .last_cyc(last_cyc)
    );

    nfe_busy #(.CW(TW)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(launch), .len(len),
        .busy(busy), .done(done)
    );

    // Command state, page port, status fail bit and identifier index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MD_READ; osel <= OUT_NONE; op_q <= OP_READ;
            seen <= 1'b0; fail_q <= 1'b0; id_idx <= 1'b0;
            pg_we <= 1'b0; pg_col <= '0; pg_din <= '0; pg_fill <= 1'b0;
        end else begin
            pg_we   <= dat_ok;
            pg_fill <= go_rst;
            if (dat_ok) begin
                pg_col <= col; pg_din <= io_in; seen <= 1'b1;
            end
            if (launch) op_q <= op_nx;
            if (done && !launch && (op_q == OP_PROG || op_q == OP_ERASE))
                fail_q <= array_fail;
            if (go_read) mode <= MD_NONE;
            if (mode == MD_ID && last_cyc) id_idx <= 1'b0;
            if (re_evt && osel == OUT_ID) id_idx <= 1'b1;
            if (take_cmd) begin
                case (io_in)
                    C_PTR_LO, C_PTR_HI, C_PTR_SP: begin mode <= MD_READ; osel <= OUT_NONE; end
                    C_PG_SET: begin mode <= MD_PROG; seen <= 1'b0; osel <= OUT_NONE; end
                    C_ER_SET: begin mode <= MD_ERASE; osel <= OUT_NONE; end
                    C_IDENT:  begin mode <= MD_ID; osel <= OUT_ID; id_idx <= 1'b0; end
                    C_STAT:   osel <= OUT_STAT;
                    C_PG_GO:  if (go_prog)  mode <= MD_NONE;
                    C_ER_GO:  if (go_erase) mode <= MD_NONE;
                    C_RESET:  begin mode <= MD_READ; osel <= OUT_NONE; fail_q <= 1'b0; end
                    default:  ;
                endcase
            end
        end
    end

    // Read-side byte selection.
    always_comb begin
        case (osel)
            OUT_STAT: io_out = {wp_n, !busy, 5'b00000, fail_q};
            OUT_ID:   io_out = id_idx ? ID_DEVICE : ID_MAKER;
            default:  io_out = 8'h00;
        endcase
    end
    assign io_oe = !re_n && osel != OUT_NONE;
    assign rdy   = !busy;

    // R6: while busy, filtered commands change neither the mode nor the pointer
    a_r6_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_evt && io_in != C_STAT && io_in != C_RESET)
        |=> ($stable(mode) && $stable(area)));
    // R9: a confirm with no data leaves the block ready
    a_r9_no_blank_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_evt && io_in == C_PG_GO && !seen) |=> !busy);
    // R3: page writes never leave the page
    a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        pg_we |-> (pg_col < COL_W'(PAGE_BYTES)));
    // R7: the fail bit only moves at the end of an operation or on reset
    a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(take_cmd && io_in == C_RESET)) |=> $stable(fail_q));
    // R8: reset clears the row and requests a page fill
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        go_rst |=> (row_addr == '0 && pg_fill));
endmodule

// File: tb/tb_nand_cmd_front.sv
`timescale 1ns/1ps
module tb_nand_cmd_front;
    localparam int TR = 5, TP = 9, TE = 12, TS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1, array_fail = 0;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out, pg_din;
    logic io_oe, rdy, pg_we, pg_fill;
    logic [9:0] pg_col;
    logic [13:0] row_addr;

    int nchk = 0, nerr = 0;
    int area_m = 0; // 0 low, 1 high, 2 spare

    nand_cmd_front #(.T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .T_RST(TS)) dut (
        .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .wp_n(wp_n), .io_in(io_in), .array_fail(array_fail), .io_out(io_out),
        .io_oe(io_oe), .rdy(rdy), .pg_we(pg_we), .pg_col(pg_col), .pg_din(pg_din),
        .pg_fill(pg_fill), .row_addr(row_addr)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write-strobe cycle; returns at the negedge after the edge is acted on.
    task automatic wr(input logic c, input logic a, input logic [7:0] b);
        cle = c; ale = a; io_in = b; we_n = 0;
        @(negedge clk); we_n = 1;
        @(posedge clk); @(negedge clk);
        cle = 0; ale = 0;
    endtask
    task automatic cmd(input logic [7:0] b); wr(1, 0, b); endtask
    task automatic adr(input logic [7:0] b); wr(0, 1, b); endtask
    task automatic dat(input logic [7:0] b); wr(0, 0, b); endtask

    task automatic rd(output logic [7:0] v);
        re_n = 0;
        @(posedge clk); @(negedge clk);
        v = io_out;
        re_n = 1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!rdy && n < 100000) begin n++; @(negedge clk); end
    endtask

    function automatic int exp_col(input int ar, input logic [7:0] b);
        if (ar == 1) return 256 + b;
        if (ar == 2) return 512 + b[3:0];
        return b;
    endfunction
    function automatic logic [7:0] exp_stat(input logic wp, input logic ready, input logic f);
        return {wp, ready, 5'b00000, f};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] v, lo, hi, cb, d;
        int n, c0, nd, pc;
        logic f;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdy", rdy, 1); chk("R1 io_oe", io_oe, 0);
        chk("R1 row", row_addr, 0); chk("R1 pg_we", pg_we, 0);
        cmd(8'h70); rd(v); chk("R1 R7 status after reset", v, 8'hC0);
        // R7 R11 write-protect seen live in status mode without new command
        wp_n = 0; rd(v); chk("R7 R11 wp low status", v, 8'h40); wp_n = 1;

        // R10 identifier
        cmd(8'h90); adr(8'h00);
        rd(v); chk("R10 maker", v, 8'hEC);
        rd(v); chk("R10 device", v, 8'hE6);
        rd(v); chk("R10 device again", v, 8'hE6);

        // R2 R12 read: third address cycle launches, top bits dropped
        cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'hC5);
        chk("R12 read busy first cycle", rdy, 0);
        wait_rdy(n); chk("R12 read busy length", n, TR);
        chk("R2 row assembly", row_addr, {6'h05, 8'h34});

        // R2 R5 program: extra address and illegal code are ignored
        cmd(8'h80); adr(8'h20); adr(8'hA1); adr(8'h03); adr(8'h7E);
        chk("R2 extra addr row", row_addr, {6'h03, 8'hA1});
        cmd(8'h33);
        dat(8'h5A);
        chk("R5 data after illegal", pg_we, 1);
        chk("R2 R3 col after extra addr", pg_col, 10'h20);
        chk("R3 din", pg_din, 8'h5A);
        array_fail = 1; cmd(8'h10);
        wait_rdy(n); chk("R12 prog busy length", n, TP);
        cmd(8'h70); rd(v); chk("R7 R12 fail latched", v, 8'hC1);

        // R8 reset clears fail, address and fills page
        cmd(8'hFF);
        chk("R8 fill pulse", pg_fill, 1); chk("R8 row cleared", row_addr, 0);
        cmd(8'hFF); // during reset: ignored
        wait_rdy(n); chk("R8 second reset ignored", n, TS - 2);
        cmd(8'h70); rd(v); chk("R8 status after reset", v, 8'hC0);

        // R9 bare confirm codes
        cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00); cmd(8'h10);
        chk("R9 bare 10h no busy", rdy, 1);
        cmd(8'h00); cmd(8'hD0);
        chk("R9 lone D0h no busy", rdy, 1);

        // R6 R11 busy filtering with live status
        array_fail = 0;
        cmd(8'h00); cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h00); dat(8'h11); cmd(8'h10);
        cmd(8'h50);
        dat(8'h99); chk("R6 data ignored while busy", pg_we, 0);
        cmd(8'h70); rd(v); chk("R11 status busy", v, 8'h80);
        wait_rdy(n);
        rd(v); chk("R11 status turns ready", v, 8'hC0);
        cmd(8'h80); adr(8'h05); adr(8'h00); adr(8'h00); dat(8'h22);
        chk("R6 pointer unchanged by busy 50h", pg_col, 10'd5);
        // R8 reset aborts a program
        cmd(8'h10); cmd(8'hFF);
        wait_rdy(n); chk("R8 abort reset length", n, TS);

        // R12 erase
        array_fail = 1;
        cmd(8'h60); adr(8'h44); adr(8'h2A);
        chk("R12 erase not before D0", rdy, 1);
        cmd(8'hD0); chk("R12 erase busy first", rdy, 0);
        wait_rdy(n); chk("R12 erase busy length", n, TE);
        chk("R2 erase row", row_addr, {6'h2A, 8'h44});
        cmd(8'h70); rd(v); chk("R7 erase fail", v, 8'hC1);
        array_fail = 0;

        // R3 R4 spare pointer persists, only low nibble used
        cmd(8'h50); cmd(8'h80); adr(8'hF3); adr(8'h00); adr(8'h00); dat(8'h01);
        chk("R3 spare col", pg_col, 10'd515);
        cmd(8'h10); wait_rdy(n);
        cmd(8'h80); adr(8'h02); adr(8'h00); adr(8'h00); dat(8'h02);
        chk("R4 spare sticky", pg_col, 10'd514);
        cmd(8'h10); wait_rdy(n);
        // R4 high half is one-shot
        cmd(8'h01); cmd(8'h80); adr(8'h10); adr(8'h00); adr(8'h00); dat(8'h03);
        chk("R3 R4 high col", pg_col, 10'd272);
        cmd(8'h10); wait_rdy(n);
        cmd(8'h80); adr(8'h10); adr(8'h00); adr(8'h00); dat(8'h04);
        chk("R4 high reverted", pg_col, 10'd16);
        cmd(8'h10); wait_rdy(n);
        area_m = 0;

        // Random program sequences over all areas (R3 R4 R7 R12)
        for (int it = 0; it < 24; it++) begin
            pc = $urandom % 4;
            if (pc == 1) begin cmd(8'h00); area_m = 0; end
            if (pc == 2) begin cmd(8'h01); area_m = 1; end
            if (pc == 3) begin cmd(8'h50); area_m = 2; end
            cb = 8'($urandom); lo = 8'($urandom); hi = 8'($urandom);
            if (it % 4 == 0) cb = 8'hFE;
            cmd(8'h80); adr(cb); adr(lo); adr(hi);
            chk("R2 random row", row_addr, {hi[5:0], lo});
            c0 = exp_col(area_m, cb);
            nd = 1 + ($urandom % 4);
            for (int k = 0; k < nd; k++) begin
                d = 8'($urandom);
                dat(d);
                if (c0 + k < 528) begin
                    chk("R3 random we", pg_we, 1);
                    chk("R3 random col", pg_col, c0 + k);
                    chk("R3 random din", pg_din, d);
                end else begin
                    chk("R3 no write past page", pg_we, 0);
                end
            end
            f = 1'($urandom);
            array_fail = f;
            cmd(8'h10);
            wait_rdy(n); chk("R12 random prog length", n, TP);
            if (area_m == 1) area_m = 0;
            cmd(8'h70); rd(v); chk("R7 random status", v, exp_stat(1'b1, 1'b1, f));
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule